// File: doc/BRIEF.md
# Step Attenuator Serial Programming Master

This block sits on the host side of a digitally controlled RF step attenuator and programs it over a three-wire link: a serial data line, a serial clock and a latch strobe. A client hands it a five-bit attenuation code on a valid/ready handshake. The block captures the code and prefixes a zero start bit to form a six-bit word. It shifts the word out most significant bit first while the latch strobe stays low, then raises the strobe for a short pulse so that the attenuator applies the new setting.

Every timing rule of the link is a parameter counted in system clock cycles. These rules are the serial clock high time, the data hold after a falling edge, the data setup before a rising edge, the strobe setup after the last falling edge and the strobe pulse width. A spacing counter keeps successive updates far enough apart to respect the attenuator's maximum switching rate. At 50 MHz, 40 µs is 2000 cycles. `busy` marks a transfer in progress and `done` pulses once when the strobe has fallen.

Top module: `atten_ser_ctrl`

## Requirements
- R1: During and after a synchronous reset, `ser_clk`, `ser_le`, `ser_dat`, `busy` and `done` are low and `req_ready` is high, including when reset interrupts a transfer.
- R2: Each update produces exactly 6 rising edges of `ser_clk`. The values of `ser_dat` sampled at those edges are, in order, 0 (start bit), then `req_att[4]` (8 dB), `req_att[3]` (4 dB), `req_att[2]` (2 dB), `req_att[1]` (1 dB) and `req_att[0]` (0.5 dB).
- R3: `ser_le` is low whenever `ser_clk` is high and throughout shifting. It rises exactly once per update, and only after the sixth rising edge.
- R4: `ser_clk` stays high for at least CLK_HI_CYC cycles. Between a falling and the next rising edge it stays low for at least DAT_HOLD_CYC + DAT_SETUP_CYC cycles.
- R5: `ser_dat` never changes while `ser_clk` is high or in the cycle it rises. It changes no sooner than DAT_HOLD_CYC cycles after a falling edge, and it is stable for at least DAT_SETUP_CYC cycles before each rising edge.
- R6: `ser_le` rises at least LE_SETUP_CYC cycles after the last falling edge of `ser_clk` and stays high for at least LE_PULSE_CYC cycles.
- R7: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `busy` is high from the next cycle until the last cycle `ser_le` is high, and `req_ready` is low whenever `busy` is high.
- R8: `done` is high for exactly one cycle: the first cycle in which `ser_le` is low again.
- R9: `req_ready` stays low for UPDATE_GAP_CYC cycles starting with the `done` cycle. A request held valid is taken exactly UPDATE_GAP_CYC cycles after the `done` cycle.
- R10: The code is captured in the accepting cycle. Changes on `req_att` afterwards do not alter the word being shifted.
- R11: After reset, a request is accepted at once, without waiting out any update spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Attenuation request present |
| req_att | input | ATT_W | Attenuation code, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| req_ready | output | 1 | Controller idle and update spacing elapsed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the latch strobe falls |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_dat | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
The properties assume a few things about the client. `rst` is asserted for at least one clock edge before traffic starts. `req_valid` is driven only from registers in the same clock domain. Every timing parameter is at least one cycle. The bench changes inputs only at the falling edge of the system clock. It holds `req_valid` high until it sees `req_ready` in the same cycle, and it changes `req_att` only after the accepting edge. Because of this, the handshake and the capture of the code are always judged on settled values.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  // sequencer phases of one attenuation update
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for a request
    ST_SETUP = 3'd1,  // clock low, data presented ahead of the rising edge
    ST_HIGH  = 3'd2,  // clock high, attenuator samples data
    ST_HOLD  = 3'd3,  // clock low, previous bit kept after the falling edge
    ST_LESU  = 3'd4,  // clock low after last bit, strobe still low
    ST_LEHI  = 3'd5   // strobe high
  } seq_state_t;

endpackage

// File: rtl/atten_ser_timer.sv
module atten_ser_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/atten_ser_shifter.sv
module atten_ser_shifter #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb
);

  logic [WORD_W-1:0] sr_q;

  // one flop per stage; stage 0 refills with zero on a shift
  for (genvar g = 0; g < WORD_W; g++) begin : g_stage
    logic nxt;
    if (g == 0) begin : g_first
      assign nxt = 1'b0;
    end else begin : g_chain
      assign nxt = sr_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        sr_q[g] <= 1'b0;
      end else if (load) begin
        sr_q[g] <= load_word[g];
      end else if (shift) begin
        sr_q[g] <= nxt;
      end
    end
  end

  assign msb = sr_q[WORD_W-1];

endmodule

// File: rtl/atten_ser_ctrl.sv
module atten_ser_ctrl
  import atten_ser_pkg::*;
#(
  parameter int ATT_W          = 5,
  parameter int CLK_HI_CYC     = 3,
  parameter int DAT_SETUP_CYC  = 2,
  parameter int DAT_HOLD_CYC   = 1,
  parameter int LE_SETUP_CYC   = 2,
  parameter int LE_PULSE_CYC   = 2,
  parameter int UPDATE_GAP_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ATT_W-1:0] req_att,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic             ser_clk,
  output logic             ser_dat,
  output logic             ser_le
);

  localparam int FRAME_W = ATT_W + 1;
  localparam int BIT_W   = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam int PH_M1   = (CLK_HI_CYC > DAT_SETUP_CYC) ? CLK_HI_CYC : DAT_SETUP_CYC;
  localparam int PH_M2   = (DAT_HOLD_CYC > LE_SETUP_CYC) ? DAT_HOLD_CYC : LE_SETUP_CYC;
  localparam int PH_M3   = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
  localparam int PH_MAX  = (PH_M3 > LE_PULSE_CYC) ? PH_M3 : LE_PULSE_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int GAP_W   = $clog2(UPDATE_GAP_CYC + 1);

  localparam logic [PH_W-1:0]  LD_SETUP = PH_W'(DAT_SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  LD_HIGH  = PH_W'(CLK_HI_CYC - 1);
  localparam logic [PH_W-1:0]  LD_HOLD  = PH_W'(DAT_HOLD_CYC - 1);
  localparam logic [PH_W-1:0]  LD_LESU  = PH_W'(LE_SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  LD_LEHI  = PH_W'(LE_PULSE_CYC - 1);
  localparam logic [GAP_W-1:0] LD_GAP   = GAP_W'(UPDATE_GAP_CYC);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);

  seq_state_t       state_q;
  logic [BIT_W-1:0] bits_left_q;
  logic             clk_q, le_q, done_q;
  logic             ph_load, ph_exp;
  logic [PH_W-1:0]  ph_val;
  logic             gap_load, gap_exp;
  logic             accept, shift, last_bit;

  assign accept   = req_valid && req_ready;
  assign last_bit = (bits_left_q == '0);
  assign shift    = (state_q == ST_HOLD) && ph_exp;
  assign gap_load = (state_q == ST_LEHI) && ph_exp;

  // phase length selection: each phase timer load sets the length of the next phase
  always_comb begin
    ph_load = 1'b0;
    ph_val  = LD_SETUP;
    case (state_q)
      ST_IDLE:  if (accept) begin ph_load = 1'b1; ph_val = LD_SETUP; end
      ST_SETUP: if (ph_exp) begin ph_load = 1'b1; ph_val = LD_HIGH;  end
      ST_HIGH:  if (ph_exp) begin ph_load = 1'b1; ph_val = last_bit ? LD_LESU : LD_HOLD; end
      ST_HOLD:  if (ph_exp) begin ph_load = 1'b1; ph_val = LD_SETUP; end
      ST_LESU:  if (ph_exp) begin ph_load = 1'b1; ph_val = LD_LEHI;  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bits_left_q <= '0;
      clk_q       <= 1'b0;
      le_q        <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_SETUP;
            bits_left_q <= LAST_IDX;
          end
        end
        ST_SETUP: begin
          if (ph_exp) begin
            state_q <= ST_HIGH;
            clk_q   <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (ph_exp) begin
            clk_q   <= 1'b0;
            state_q <= last_bit ? ST_LESU : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ph_exp) begin
            state_q     <= ST_SETUP;
            bits_left_q <= bits_left_q - 1'b1;
          end
        end
        ST_LESU: begin
          if (ph_exp) begin
            state_q <= ST_LEHI;
            le_q    <= 1'b1;
          end
        end
        ST_LEHI: begin
          if (ph_exp) begin
            state_q <= ST_IDLE;
            le_q    <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  atten_ser_timer #(.CNT_W(PH_W)) u_phase_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .expired  (ph_exp)
  );

  atten_ser_timer #(.CNT_W(GAP_W)) u_gap_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (LD_GAP),
    .expired  (gap_exp)
  );

  atten_ser_shifter #(.WORD_W(FRAME_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word ({1'b0, req_att}),
    .shift     (shift),
    .msb       (ser_dat)
  );

  assign req_ready = (state_q == ST_IDLE) && gap_exp;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ser_clk   = clk_q;
  assign ser_le    = le_q;

endmodule

// File: rtl/atten_ser_ctrl_chk.sv
module atten_ser_ctrl_chk #(
  parameter int CLK_HI_CYC     = 3,
  parameter int UPDATE_GAP_CYC = 2000
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_dat,
  input logic ser_le
);

  localparam int GW = $clog2(UPDATE_GAP_CYC + 1) + 1;

  logic [15:0]   hi_cnt;
  logic [GW-1:0] gap_cnt;
  logic          seen_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      gap_cnt   <= '0;
      seen_done <= 1'b0;
    end else begin
      if (!ser_clk)               hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
      if (done) begin
        gap_cnt   <= GW'(1);
        seen_done <= 1'b1;
      end else if (gap_cnt <= GW'(UPDATE_GAP_CYC)) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && !ser_le));

  p_le_low_clk_high_r3: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> !ser_le);

  p_clk_high_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_clk) |-> (hi_cnt >= 16'(CLK_HI_CYC)));

  p_dat_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_dat));

  p_ready_excl_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_on_le_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_le) |-> done);

  p_gap_spacing_r9: assert property (@(posedge clk) disable iff (rst)
    (seen_done && req_valid && req_ready) |-> (gap_cnt >= GW'(UPDATE_GAP_CYC)));

endmodule

bind atten_ser_ctrl atten_ser_ctrl_chk #(
  .CLK_HI_CYC     (CLK_HI_CYC),
  .UPDATE_GAP_CYC (UPDATE_GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .ser_clk   (ser_clk),
  .ser_dat   (ser_dat),
  .ser_le    (ser_le)
);

// File: tb/test_atten_ser_ctrl.sv
`timescale 1ns/1ps
module test_atten_ser_ctrl;

  localparam int ATT_W = 5;
  localparam int HI    = 3;
  localparam int SU    = 2;
  localparam int HOLD  = 1;
  localparam int LESU  = 2;
  localparam int LEPW  = 2;
  localparam int GAP   = 2000;
  localparam int NVEC  = 8;

  // each entry: {attenuation code, expected 6-bit word on the line}
  localparam logic [10:0] VEC [NVEC] = '{
    {5'b00000, 6'b000000},
    {5'b11111, 6'b011111},
    {5'b10101, 6'b010101},
    {5'b01010, 6'b001010},
    {5'b00001, 6'b000001},
    {5'b10000, 6'b010000},
    {5'b01100, 6'b001100},
    {5'b10011, 6'b010011}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ATT_W-1:0] req_att = '0;
  logic req_ready, busy, done, ser_clk, ser_dat, ser_le;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_done_cyc = 0;

  // line monitor state
  logic [5:0] cap_frame = '0;
  int rise_cnt = 0, le_rises = 0;
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0;
  int lo_run = 1000, hi_run = 0, dat_age = 1000, since_fall = 1000, le_hi = 0;
  logic prev_clk = 1'b0, prev_le = 1'b0, prev_dat = 1'b0, prev_busy = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  atten_ser_ctrl #(
    .ATT_W(ATT_W), .CLK_HI_CYC(HI), .DAT_SETUP_CYC(SU), .DAT_HOLD_CYC(HOLD),
    .LE_SETUP_CYC(LESU), .LE_PULSE_CYC(LEPW), .UPDATE_GAP_CYC(GAP)
  ) i_atten_ser_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_att(req_att),
    .req_ready(req_ready), .busy(busy), .done(done),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le)
  );

  always @(negedge clk) begin
    if (rst) begin
      lo_run = 1000; hi_run = 0; dat_age = 1000; since_fall = 1000; le_hi = 0;
    end else begin
      if (busy && !prev_busy) begin
        cap_frame = '0; rise_cnt = 0; le_rises = 0;
      end
      if (ser_clk && !prev_clk) begin
        cap_frame = {cap_frame[4:0], ser_dat};
        rise_cnt++;
        if (ser_le) v_r3++;
        if (lo_run < SU + HOLD) v_r4++;
        if (dat_age < SU) v_r5++;
      end
      if (!ser_clk && prev_clk && hi_run < HI) v_r4++;
      if (ser_dat != prev_dat) begin
        if (ser_clk) v_r5++;
        if (since_fall < HOLD) v_r5++;
      end
      if (ser_le && !prev_le) begin
        le_rises++;
        if (rise_cnt != 6) v_r3++;
        if (since_fall < LESU) v_r6++;
      end
      if (!ser_le && prev_le) begin
        if (le_hi < LEPW) v_r6++;
        if (!done) v_r8++;
      end
      if (!ser_clk && prev_clk) since_fall = 1; else since_fall++;
      if (ser_dat != prev_dat) dat_age = 1; else dat_age++;
      if (ser_clk) begin lo_run = 0; hi_run++; end else begin lo_run++; hi_run = 0; end
      if (ser_le) le_hi++; else le_hi = 0;
    end
    prev_clk = ser_clk; prev_le = ser_le; prev_dat = ser_dat; prev_busy = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(!ser_clk, "R1", {tag, " ser_clk"}, int'(ser_clk), 0);
    chk(!ser_le,  "R1", {tag, " ser_le"},  int'(ser_le), 0);
    chk(!ser_dat, "R1", {tag, " ser_dat"}, int'(ser_dat), 0);
    chk(!busy,    "R1", {tag, " busy"},    int'(busy), 0);
    chk(!done,    "R1", {tag, " done"},    int'(done), 0);
    chk(req_ready, "R11", {tag, " req_ready"}, int'(req_ready), 1);
  endtask

  task automatic run_vec(input logic [4:0] att, input logic [5:0] exp_frame,
                         input bit check_gap);
    int acc_cyc;
    @(negedge clk);
    req_valid = 1'b1;
    req_att   = att;
    while (!req_ready) @(negedge clk);
    acc_cyc = cyc;
    if (check_gap)
      chk(acc_cyc - last_done_cyc == GAP, "R9", "accept spacing after done",
          acc_cyc - last_done_cyc, GAP);
    @(negedge clk);
    req_valid = 1'b0;
    req_att   = ~att;  // R10: must not reach the line
    chk(busy && !req_ready, "R7", "busy set, ready clear after accept",
        int'({busy, req_ready}), 2);
    while (!done) @(negedge clk);
    last_done_cyc = cyc;
    chk(!ser_le && !busy, "R8", "done cycle has strobe low and busy clear",
        int'({ser_le, busy}), 0);
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", int'(done), 0);
    chk(cap_frame == exp_frame, "R2", "shifted word", int'(cap_frame), int'(exp_frame));
    chk(rise_cnt == 6, "R2", "rising edges per update", rise_cnt, 6);
    chk(le_rises == 1, "R3", "strobe pulses per update", le_rises, 1);
    chk(v_r3 == 0, "R3", "strobe during shifting", v_r3, 0);
    chk(v_r4 == 0, "R4", "clock phase widths", v_r4, 0);
    chk(v_r5 == 0, "R5", "data change timing", v_r5, 0);
    chk(v_r6 == 0, "R6", "strobe setup and width", v_r6, 0);
    chk(v_r8 == 0, "R8", "done at strobe fall", v_r8, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check_idle("in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("after reset");

    // table walk: first entry right after reset (R11), rest back to back (R9, R10)
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VEC[i][10:6], VEC[i][5:0], i != 0);
    end

    // reset in the middle of a transfer
    @(negedge clk);
    req_valid = 1'b1;
    req_att   = 5'b11011;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(busy, "R7", "busy mid transfer", int'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    check_idle("reset mid transfer");
    rst = 1'b0;
    @(negedge clk);
    check_idle("release mid transfer");

    // immediate acceptance after reset, then one spaced update
    run_vec(5'b11011, 6'b011011, 1'b0);
    run_vec(5'b00110, 6'b000110, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule